// File: doc/BRIEF.md
# Vertex History Signature Unit

This execute-stage unit builds the history signature of one instruction's destination value. The signature is a CRC over the signatures of the instruction's operands, its immediate and its operation identifier. Two different dataflow shapes feeding the same instruction therefore give different signatures, with high probability. Each operand arrives with a history signature, a data word and a parity bit. A per-operand flag says that the value was produced in an earlier basic block. When the flag is set, the unit hashes that source register's initial signature in place of the live one.

Alongside the executed signature, the unit emits the destination register's initial signature. Consumers in later blocks use it in place of the executed one. The unit also checks operand parity and produces parity for the result. The CRC and the initial-signature table are combinational. A parameter selects whether the outputs pass through one register stage (the default) or leave the unit directly.

Top module: `vhs_unit`

## Requirements
- R1: `sig_ex_o` is a 10-bit CRC with polynomial x^10+x^3+1. The CRC state starts at 10'h3FF. Each bit is fed MSB first: fb = state[9]^bit, then state = {state[8:0],0} ^ (fb ? 10'h009 : 0). The 47-bit message, in this order, is: A-valid, A signature(10), B-valid, B signature(10), imm-valid, immediate(16), operation id(8).
- R2: An operand or immediate that is not used contributes all-zero bits and a valid bit of 0. A used input contributes a valid bit of 1. An absent input and a present all-zero input therefore give different signatures.
- R3: When an operand is used and its prev-block flag is 1, the signature hashed for it is the initial signature of its source register. Its live signature input has no effect in that case.
- R4: `sig_init_o` is the initial signature of `dst_reg_i`. The initial signature of a register uses a 5-bit seed equal to the register number. It is the CRC of R1, from 10'h3FF, over the 8 bits {3'b101, seed}, fed MSB first.
- R5: `par_o` is the XOR of all bits of `result_i` (even parity).
- R6: `par_err_o` is 1 when a used operand's parity bit differs from the XOR of its data bits. The parity of an unused operand is ignored.
- R7: With registered outputs, the results of a strobe on `valid_i` appear on the next clock, together with `valid_o`=1. `par_err_o` is high only in a cycle where `valid_o` is high, and it drops to 0 in the cycle after a lone strobe.
- R8: After reset, `valid_o`, `par_err_o`, `par_o`, `sig_ex_o` and `sig_init_o` are 0.
- R9: While `valid_i` is 0, `sig_ex_o`, `sig_init_o` and `par_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| a_used_i | input | 1 | Operand A present |
| a_prev_i | input | 1 | Operand A produced in an earlier block |
| a_reg_i | input | 5 | Operand A source register |
| a_sig_i | input | 10 | Operand A live signature |
| a_data_i | input | DATA_W | Operand A data |
| a_par_i | input | 1 | Operand A parity bit |
| b_used_i | input | 1 | Operand B present |
| b_prev_i | input | 1 | Operand B produced in an earlier block |
| b_reg_i | input | 5 | Operand B source register |
| b_sig_i | input | 10 | Operand B live signature |
| b_data_i | input | DATA_W | Operand B data |
| b_par_i | input | 1 | Operand B parity bit |
| imm_used_i | input | 1 | Immediate present |
| imm_i | input | IMM_W | Immediate |
| op_id_i | input | OPID_W | Operation identifier |
| dst_reg_i | input | 5 | Destination register |
| result_i | input | DATA_W | Result data |
| valid_o | output | 1 | Outputs updated |
| sig_ex_o | output | 10 | Executed destination signature |
| sig_init_o | output | 10 | Destination initial signature |
| par_o | output | 1 | Result parity |
| par_err_o | output | 1 | Operand parity error |

## Verification
The assertions check on every cycle the pipeline timing of `valid_o`, the result parity, and that `par_err_o` only ever accompanies `valid_o`. They also check that it stays low when no operand is used, and that `sig_init_o` stays put for a repeated destination. The CRC values themselves, the prev-block substitution, the absent-versus-zero distinction and the holding of outputs while idle show only in the bench's scenarios. There, the expected signatures come from an independent model of the message and the table.

// File: rtl/vhs_pkg.sv
package vhs_pkg;
  parameter int unsigned SIG_W    = 10;
  parameter int unsigned SEED_W   = 5;
  parameter logic [SIG_W-1:0] POLY     = 10'h009;
  parameter logic [SIG_W-1:0] CRC_INIT = 10'h3FF;
  parameter logic [2:0]       INIT_TAG = 3'b101;
  localparam int unsigned NUM_SEEDS = 1 << SEED_W;

  typedef logic [SIG_W-1:0] sig_t;

  function automatic sig_t crc_step(sig_t st, logic din);
    logic fb;
    fb = st[SIG_W-1] ^ din;
    return {st[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  function automatic sig_t init_sig(logic [SEED_W-1:0] seed);
    logic [SEED_W+2:0] msg;
    sig_t st;
    msg = {INIT_TAG, seed};
    st  = CRC_INIT;
    for (int i = SEED_W + 2; i >= 0; i--) st = crc_step(st, msg[i]);
    return st;
  endfunction
endpackage

// File: rtl/vhs_crc_fold.sv
module vhs_crc_fold #(
  parameter int unsigned IN_W = 47
) (
  input  logic [IN_W-1:0]    msg_i,
  output vhs_pkg::sig_t      crc_o
);
  always_comb begin
    vhs_pkg::sig_t st;
    st = vhs_pkg::CRC_INIT;
    for (int i = IN_W - 1; i >= 0; i--) st = vhs_pkg::crc_step(st, msg_i[i]);
    crc_o = st;
  end
endmodule

// File: rtl/vhs_init_rom.sv
module vhs_init_rom (
  input  logic [vhs_pkg::SEED_W-1:0] seed_i,
  output vhs_pkg::sig_t              sig_o
);
  import vhs_pkg::*;
  sig_t table_q [NUM_SEEDS];

  for (genvar s = 0; s < NUM_SEEDS; s++) begin : g_tab
    assign table_q[s] = init_sig(SEED_W'(s));
  end

  assign sig_o = table_q[seed_i];
endmodule

// File: rtl/vhs_opnd.sv
module vhs_opnd #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                       used_i,
  input  logic                       prev_i,
  input  logic [vhs_pkg::SEED_W-1:0] reg_i,
  input  vhs_pkg::sig_t              sig_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       par_i,
  output vhs_pkg::sig_t              sig_o,
  output logic                       vld_o,
  output logic                       perr_o
);
  vhs_pkg::sig_t init_sig;

  vhs_init_rom u_rom (.seed_i(reg_i), .sig_o(init_sig));

  // absent operand contributes zeros and a cleared valid bit
  assign sig_o  = !used_i ? '0 : (prev_i ? init_sig : sig_i);
  assign vld_o  = used_i;
  assign perr_o = used_i && ((^data_i) != par_i);
endmodule

// File: rtl/vhs_unit.sv
module vhs_unit #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 16,
  parameter int unsigned OPID_W  = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       a_used_i,
  input  logic                       a_prev_i,
  input  logic [vhs_pkg::SEED_W-1:0] a_reg_i,
  input  logic [vhs_pkg::SIG_W-1:0]  a_sig_i,
  input  logic [DATA_W-1:0]          a_data_i,
  input  logic                       a_par_i,
  input  logic                       b_used_i,
  input  logic                       b_prev_i,
  input  logic [vhs_pkg::SEED_W-1:0] b_reg_i,
  input  logic [vhs_pkg::SIG_W-1:0]  b_sig_i,
  input  logic [DATA_W-1:0]          b_data_i,
  input  logic                       b_par_i,
  input  logic                       imm_used_i,
  input  logic [IMM_W-1:0]           imm_i,
  input  logic [OPID_W-1:0]          op_id_i,
  input  logic [vhs_pkg::SEED_W-1:0] dst_reg_i,
  input  logic [DATA_W-1:0]          result_i,
  output logic                       valid_o,
  output logic [vhs_pkg::SIG_W-1:0]  sig_ex_o,
  output logic [vhs_pkg::SIG_W-1:0]  sig_init_o,
  output logic                       par_o,
  output logic                       par_err_o
);
  import vhs_pkg::*;
  localparam int unsigned N_OPND = 2;
  localparam int unsigned MSG_W  = N_OPND * (SIG_W + 1) + 1 + IMM_W + OPID_W;

  logic                used   [N_OPND];
  logic                prev   [N_OPND];
  logic [SEED_W-1:0]   sreg   [N_OPND];
  sig_t                lsig   [N_OPND];
  logic [DATA_W-1:0]   data   [N_OPND];
  logic                par    [N_OPND];
  sig_t                hsig   [N_OPND];
  logic                hvld   [N_OPND];
  logic                perr   [N_OPND];

  assign used[0] = a_used_i;  assign used[1] = b_used_i;
  assign prev[0] = a_prev_i;  assign prev[1] = b_prev_i;
  assign sreg[0] = a_reg_i;   assign sreg[1] = b_reg_i;
  assign lsig[0] = a_sig_i;   assign lsig[1] = b_sig_i;
  assign data[0] = a_data_i;  assign data[1] = b_data_i;
  assign par[0]  = a_par_i;   assign par[1]  = b_par_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    vhs_opnd #(.DATA_W(DATA_W)) u_opnd (
      .used_i(used[g]), .prev_i(prev[g]), .reg_i(sreg[g]), .sig_i(lsig[g]),
      .data_i(data[g]), .par_i(par[g]),
      .sig_o(hsig[g]), .vld_o(hvld[g]), .perr_o(perr[g])
    );
  end

  logic [MSG_W-1:0] msg;
  assign msg = {hvld[0], hsig[0], hvld[1], hsig[1],
                imm_used_i, (imm_used_i ? imm_i : {IMM_W{1'b0}}), op_id_i};

  sig_t ex_sig, dst_init;
  vhs_crc_fold #(.IN_W(MSG_W)) u_crc (.msg_i(msg), .crc_o(ex_sig));
  vhs_init_rom u_dst_rom (.seed_i(dst_reg_i), .sig_o(dst_init));

  logic res_par, err_c;
  assign res_par = ^result_i;
  assign err_c   = valid_i && (perr[0] || perr[1]);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o    <= 1'b0;
        par_err_o  <= 1'b0;
        sig_ex_o   <= '0;
        sig_init_o <= '0;
        par_o      <= 1'b0;
      end else begin
        valid_o   <= valid_i;
        par_err_o <= err_c;
        if (valid_i) begin
          sig_ex_o   <= ex_sig;
          sig_init_o <= dst_init;
          par_o      <= res_par;
        end
      end
    end
  end else begin : g_comb
    assign valid_o    = valid_i;
    assign par_err_o  = err_c;
    assign sig_ex_o   = ex_sig;
    assign sig_init_o = dst_init;
    assign par_o      = res_par;
  end
endmodule

// File: rtl/vhs_unit_chk.sv
module vhs_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic                       a_used_i,
  input logic                       b_used_i,
  input logic [vhs_pkg::SEED_W-1:0] dst_reg_i,
  input logic [DATA_W-1:0]          result_i,
  input logic                       valid_o,
  input logic [vhs_pkg::SIG_W-1:0]  sig_init_o,
  input logic                       par_o,
  input logic                       par_err_o
);
  if (OUT_REG) begin : g_chk
    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R7
    AST_IDLE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R7
    AST_ERR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      par_err_o |-> valid_o); // R7
    AST_NO_USED_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !a_used_i && !b_used_i) |=> !par_err_o); // R6
    AST_RES_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (par_o == ^$past(result_i))); // R5
    AST_INIT_SAME_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && valid_o && $past(valid_i) && (dst_reg_i == $past(dst_reg_i)))
      |=> (sig_init_o == $past(sig_init_o))); // R4
  end
endmodule

bind vhs_unit vhs_unit_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_vhs_unit.sv
`timescale 1ns/1ps
module sim_vhs_unit;
  localparam int DATA_W = 32, IMM_W = 16, OPID_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic valid = 0, a_used = 0, a_prev = 0, a_par = 0, b_used = 0, b_prev = 0, b_par = 0, imm_used = 0;
  logic [4:0] a_reg = 0, b_reg = 0, dst_reg = 0;
  logic [9:0] a_sig = 0, b_sig = 0;
  logic [DATA_W-1:0] a_data = 0, b_data = 0, result = 0;
  logic [IMM_W-1:0] imm = 0;
  logic [OPID_W-1:0] op_id = 0;
  logic valid_o, par_o, par_err_o;
  logic [9:0] sig_ex_o, sig_init_o;

  vhs_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .a_used_i(a_used), .a_prev_i(a_prev), .a_reg_i(a_reg), .a_sig_i(a_sig), .a_data_i(a_data), .a_par_i(a_par),
    .b_used_i(b_used), .b_prev_i(b_prev), .b_reg_i(b_reg), .b_sig_i(b_sig), .b_data_i(b_data), .b_par_i(b_par),
    .imm_used_i(imm_used), .imm_i(imm), .op_id_i(op_id), .dst_reg_i(dst_reg), .result_i(result),
    .valid_o(valid_o), .sig_ex_o(sig_ex_o), .sig_init_o(sig_init_o), .par_o(par_o), .par_err_o(par_err_o)
  );

  int checks = 0, errors = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_crc(logic [63:0] msg, int n);
    logic [9:0] st = 10'h3FF;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = st[9] ^ msg[i];
      st = {st[8:0], 1'b0} ^ (fb ? 10'h009 : 10'h000);
    end
    return st;
  endfunction

  function automatic logic [9:0] ref_init(logic [4:0] s);
    return ref_crc({56'd0, 3'b101, s}, 8);
  endfunction

  function automatic logic [9:0] ref_ex();
    logic [9:0] sa, sb;
    sa = !a_used ? 10'd0 : (a_prev ? ref_init(a_reg) : a_sig);
    sb = !b_used ? 10'd0 : (b_prev ? ref_init(b_reg) : b_sig);
    return ref_crc({17'd0, a_used, sa, b_used, sb, imm_used, (imm_used ? imm : 16'd0), op_id}, 47);
  endfunction

  // one strobe, check on the following negedge
  task automatic run_op(string req, output logic [9:0] got);
    logic [9:0] e_ex, e_init;
    logic e_par, e_err;
    e_ex   = ref_ex();
    e_init = ref_init(dst_reg);
    e_par  = ^result;
    e_err  = (a_used && ((^a_data) != a_par)) || (b_used && ((^b_data) != b_par));
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check({req, " R7 valid_o"}, 32'(valid_o), 32'd1);
    check({req, " R1 sig_ex"}, 32'(sig_ex_o), 32'(e_ex));
    check({req, " R4 sig_init"}, 32'(sig_init_o), 32'(e_init));
    check({req, " R5 par_o"}, 32'(par_o), 32'(e_par));
    check({req, " R6 par_err"}, 32'(par_err_o), 32'(e_err));
    got = sig_ex_o;
    @(negedge clk);
  endtask

  task automatic clear_in();
    a_used = 0; a_prev = 0; a_reg = 0; a_sig = 0; a_data = 0; a_par = 0;
    b_used = 0; b_prev = 0; b_reg = 0; b_sig = 0; b_data = 0; b_par = 0;
    imm_used = 0; imm = 0; op_id = 0; dst_reg = 0; result = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] s1, s2, s3, held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid_o", 32'(valid_o), 0);
    check("R8 par_err_o", 32'(par_err_o), 0);
    check("R8 sig_ex_o", 32'(sig_ex_o), 0);
    check("R8 sig_init_o", 32'(sig_init_o), 0);
    check("R8 par_o", 32'(par_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 absent A vs present all-zero A
    clear_in(); op_id = 8'h05;
    run_op("R2 absent", s1);
    a_used = 1;
    run_op("R2 zero", s2);
    check("R2 absent differs from zero", 32'(s1 != s2), 1);
    // R2 absent vs zero immediate
    clear_in(); op_id = 8'h11; imm_used = 1;
    run_op("R2 imm zero", s3);
    imm_used = 0; imm = 16'hBEEF;
    run_op("R2 imm absent ignores value", s1);
    imm = 16'h0000;
    run_op("R2 imm absent", s2);
    check("R2 absent imm value ignored", 32'(s1), 32'(s2));
    check("R2 imm absent vs zero", 32'(s2 != s3), 1);

    // R3 prev flag replaces live signature
    clear_in(); a_used = 1; a_prev = 1; a_reg = 5'd7; a_sig = 10'h155; op_id = 8'h06;
    run_op("R3 prev a", s1);
    a_sig = 10'h2AA;
    run_op("R3 prev a live ignored", s2);
    check("R3 live sig no effect", 32'(s1), 32'(s2));
    b_used = 1; b_prev = 1; b_reg = 5'd31; b_sig = 10'h3FF;
    run_op("R3 prev b", s3);

    // R4 table corners
    clear_in(); dst_reg = 5'd0;  run_op("R4 dst0", s1);
    dst_reg = 5'd31; run_op("R4 dst31", s1);

    // R6 parity error on used A, then gone
    clear_in(); a_used = 1; a_data = 32'h1; a_par = 1'b0;
    run_op("R6 a bad", s1);
    check("R7 err cleared after strobe", 32'(par_err_o), 0);
    check("R7 valid_o low when idle", 32'(valid_o), 0);
    // R6 unused B with bad parity ignored
    clear_in(); a_used = 1; b_data = 32'h3; b_par = 1'b1;
    run_op("R6 b unused bad", s1);
    b_used = 1;
    run_op("R6 b used bad", s1);

    // R9 hold while idle
    clear_in(); a_used = 1; a_sig = 10'h0F0; dst_reg = 5'd9; result = 32'h7;
    run_op("R9 load", held);
    a_sig = 10'h00F; dst_reg = 5'd3; result = 32'h0;
    repeat (3) @(negedge clk);
    check("R9 sig_ex held", 32'(sig_ex_o), 32'(held));
    check("R9 sig_init held", 32'(sig_init_o), 32'(ref_init(5'd9)));
    check("R9 par_o held", 32'(par_o), 1);

    // random mix, R1 main function
    for (int n = 0; n < 400; n++) begin
      a_used = 1'($urandom); a_prev = 1'($urandom); a_reg = 5'($urandom); a_sig = 10'($urandom);
      a_data = $urandom; a_par = ((^a_data) ^ (($urandom % 8) == 0));
      b_used = 1'($urandom); b_prev = 1'($urandom); b_reg = 5'($urandom); b_sig = 10'($urandom);
      b_data = $urandom; b_par = ((^b_data) ^ (($urandom % 8) == 0));
      imm_used = 1'($urandom); imm = 16'($urandom); op_id = 8'($urandom);
      dst_reg = 5'($urandom); result = $urandom;
      run_op("R1 random", s1);
    end
    finish_run();
  end
endmodule